// File: doc/BRIEF.md
# Timestamped Sample Capture Qualifier

This block sits between a probe sampling stage and an acquisition memory. Each sample strobe presents one sample of the probe channel group. The block packs these samples into full-width memory words according to a speed mode. In the base mode every channel goes into the word at once. In the faster modes only a half or a quarter of the channels are used: consecutive sub-samples of that subset fill the word side by side, so a narrower group is recorded at two or four times the rate. Each completed word carries a free-running timestamp with one tick per clock cycle, wide enough to cover days of capture at sub-nanosecond resolution.

Completed words go to a memory write port with its own address counter. Writing can be continuous, or it can be qualified by commands from a trigger controller. In qualified mode a sticky enable is set by a start command and cleared by a stop command. A per-word keep or drop command overrides the sticky enable for one word only. Writing stops when the address counter reaches the configured depth.

Top module: `cq_capture`

## Requirements
- R1: A synchronous reset leaves `wr_en`, `wr_addr` and `mem_full` at 0, clears the sticky enable, and restarts the timestamp so that a strobe at the first clock edge after reset is tagged 0.
- R2: In mode code 0 (and the spare code 3), each strobe completes a word equal to the whole sample bus.
- R3: In mode code 1, only the lower half of the channels is used. Two strobes make one word: the first sub-sample goes in bits [NCH/2-1:0] and the second in the upper half.
- R4: In mode code 2, only the lower quarter of the channels is used. Four strobes make one word: sub-sample k goes in bits [k*NCH/4 +: NCH/4].
- R5: `wr_ts` is the number of clock edges between the end of reset and the strobe that completes the word. Only the final sub-sample's time is kept, in every mode. The count wraps at 2^TS_W.
- R6: With `cond_mode`=0, every completed word is written and all four commands are ignored.
- R7: With `cond_mode`=1, `cmd_start` sets the sticky enable and `cmd_stop` clears it; stop wins when both are given. Either takes effect on the same cycle, including for a word completed in that cycle.
- R8: With `cond_mode`=1, `cmd_keep` forces the word completed in that cycle to be written and `cmd_drop` forces it to be discarded; drop wins over keep. Neither changes the sticky enable, and both act only with the completing strobe.
- R9: A written word appears as a one-cycle `wr_en` pulse in the cycle after the completing strobe. `wr_addr` starts at 0 and rises by one per written word.
- R10: After DEPTH words have been written, `mem_full` is 1 and nothing more is written until reset.
- R11: A change of `mode` discards any partly packed word, and the next strobe starts a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timestamp tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | NCH | Probe channel sample |
| mode | input | 2 | Speed mode: 0 full width, 1 double rate, 2 quad rate, 3 as 0 |
| cond_mode | input | 1 | 1 = qualified storage, 0 = continuous |
| cmd_keep | input | 1 | Write the word completed this cycle |
| cmd_drop | input | 1 | Discard the word completed this cycle |
| cmd_start | input | 1 | Set the sticky store enable |
| cmd_stop | input | 1 | Clear the sticky store enable |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | $clog2(DEPTH) | Memory write address |
| wr_data | output | NCH | Packed memory word |
| wr_ts | output | TS_W | Timestamp of the word |
| mem_full | output | 1 | Depth reached, writing halted |

## Verification
A sub-sample index that has slipped shows up as a misplaced lane in `wr_data`, or as a `wr_en` pulse one strobe early or late, in the cycle after the next completing strobe. A sticky enable in the wrong state shows up as a missing or extra pulse on the next plain word in qualified mode. A counting error in the timestamp or the address appears in the next written word. A full-flag error appears at the DEPTH-th write, as a write that continues or a flag that stays low.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    MODE_X1  = 2'd0,
    MODE_X2  = 2'd1,
    MODE_X4  = 2'd2,
    MODE_RSV = 2'd3
  } cq_mode_e;

  // index of the sub-sample that closes a word
  function automatic logic [1:0] last_sub(input cq_mode_e m);
    case (m)
      MODE_X2: return 2'd1;
      MODE_X4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // storage verdict for a word in qualified mode
  function automatic logic verdict(input logic keep, input logic drop,
                                   input logic sticky);
    if (drop) return 1'b0;
    if (keep) return 1'b1;
    return sticky;
  endfunction

endpackage

// File: rtl/cq_tstamp.sv
module cq_tstamp #(
  parameter int TS_W = 51
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);

  function automatic logic [TS_W-1:0] next_ts(input logic [TS_W-1:0] t);
    return t + TS_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= next_ts(ts);
  end

endmodule

// File: rtl/cq_packer.sv
module cq_packer
  import cq_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_vld,
  input  logic [NCH-1:0] smp_data,
  input  cq_mode_e       mode,
  output logic           word_done,
  output logic [NCH-1:0] word
);

  localparam int HALF = NCH / 2;
  localparam int QTR  = NCH / 4;

  logic [NCH-1:0] acc_q;
  logic [1:0]     idx_q;
  logic [1:0]     idx_eff;
  cq_mode_e       mode_q;
  logic           mode_chg;

  function automatic logic [NCH-1:0] place(input logic [NCH-1:0] acc,
                                           input logic [NCH-1:0] d,
                                           input cq_mode_e m,
                                           input logic [1:0] idx);
    logic [NCH-1:0] r;
    r = acc;
    case (m)
      MODE_X2: r[int'(idx[0]) * HALF +: HALF] = d[HALF-1:0];
      MODE_X4: r[int'(idx) * QTR +: QTR]     = d[QTR-1:0];
      default: r = d;
    endcase
    return r;
  endfunction

  always_comb begin
    mode_chg  = (mode != mode_q);
    idx_eff   = mode_chg ? 2'd0 : idx_q;
    word      = place(acc_q, smp_data, mode, idx_eff);
    word_done = smp_vld && (idx_eff == last_sub(mode));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      idx_q  <= 2'd0;
      mode_q <= MODE_X1;
    end else begin
      mode_q <= mode;
      if (smp_vld) begin
        acc_q <= word;
        idx_q <= word_done ? 2'd0 : idx_eff + 2'd1;
      end else if (mode_chg) begin
        idx_q <= 2'd0;
      end
    end
  end

endmodule

// File: rtl/cq_qualifier.sv
module cq_qualifier
  import cq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic word_done,
  input  logic cond_mode,
  input  logic cmd_keep,
  input  logic cmd_drop,
  input  logic cmd_start,
  input  logic cmd_stop,
  output logic keep_word,
  output logic store_en
);

  logic en_now;

  always_comb begin
    if (cmd_stop)       en_now = 1'b0;
    else if (cmd_start) en_now = 1'b1;
    else                en_now = store_en;
    keep_word = word_done &&
                (!cond_mode || verdict(cmd_keep, cmd_drop, en_now));
  end

  always_ff @(posedge clk) begin
    if (rst) store_en <= 1'b0;
    else     store_en <= en_now;
  end

endmodule

// File: rtl/cq_writer.sv
module cq_writer #(
  parameter int NCH   = 16,
  parameter int TS_W  = 51,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     keep_word,
  input  logic [NCH-1:0]           word,
  input  logic [TS_W-1:0]          ts,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [NCH-1:0]           wr_data,
  output logic [TS_W-1:0]          wr_ts,
  output logic                     mem_full
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;
  logic          do_wr;

  assign mem_full = (cnt_q == CW'(DEPTH));
  assign do_wr    = keep_word && !mem_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_ts   <= '0;
      cnt_q   <= '0;
    end else begin
      wr_en <= do_wr;
      if (do_wr) begin
        wr_addr <= cnt_q[AW-1:0];
        wr_data <= word;
        wr_ts   <= ts;
        cnt_q   <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/cq_capture.sv
module cq_capture
  import cq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int TS_W  = 51,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic [NCH-1:0]           smp_data,
  input  logic [1:0]               mode,
  input  logic                     cond_mode,
  input  logic                     cmd_keep,
  input  logic                     cmd_drop,
  input  logic                     cmd_start,
  input  logic                     cmd_stop,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [NCH-1:0]           wr_data,
  output logic [TS_W-1:0]          wr_ts,
  output logic                     mem_full
);

  logic [TS_W-1:0] ts_now;
  logic            word_done;
  logic [NCH-1:0]  word;
  logic            keep_word;
  logic            store_en;

  cq_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst(rst), .ts(ts_now)
  );

  cq_packer #(.NCH(NCH)) u_pack (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .mode(cq_mode_e'(mode)), .word_done(word_done), .word(word)
  );

  cq_qualifier u_qual (
    .clk(clk), .rst(rst), .word_done(word_done), .cond_mode(cond_mode),
    .cmd_keep(cmd_keep), .cmd_drop(cmd_drop), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .keep_word(keep_word), .store_en(store_en)
  );

  cq_writer #(.NCH(NCH), .TS_W(TS_W), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .keep_word(keep_word), .word(word), .ts(ts_now),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ts(wr_ts),
    .mem_full(mem_full)
  );

endmodule

// File: rtl/cq_capture_chk.sv
module cq_capture_chk #(
  parameter int AW   = 3,
  parameter int TS_W = 51
) (
  input logic          clk,
  input logic          rst,
  input logic          cond_mode,
  input logic          cmd_start,
  input logic          cmd_stop,
  input logic          word_done,
  input logic          keep_word,
  input logic          store_en,
  input logic          mem_full,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [TS_W-1:0] wr_ts
);

  // R10
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && wr_en |-> !$past(mem_full));

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && wr_en && $past(wr_en) |-> wr_addr == AW'($past(wr_addr) + 1'b1));

  // R9
  write_follows_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && wr_en |-> $past(keep_word));

  // R6
  continuous_writes_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(word_done && !cond_mode && !mem_full) |-> wr_en);

  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(cmd_stop) |-> !store_en);

  // R7
  start_sets_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(cmd_start && !cmd_stop) |-> store_en);

  // R5
  ts_advances_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && wr_en && $past(wr_en) |-> wr_ts != $past(wr_ts));

endmodule

bind cq_capture cq_capture_chk #(.AW($clog2(DEPTH)), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .cond_mode(cond_mode), .cmd_start(cmd_start),
  .cmd_stop(cmd_stop), .word_done(word_done), .keep_word(keep_word),
  .store_en(store_en), .mem_full(mem_full), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_ts(wr_ts)
);

// File: tb/cq_capture_test.sv
module cq_capture_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 16;
  localparam int TS_W  = 51;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);

  localparam int NV = 6;
  localparam logic [15:0] V_DATA [NV] = '{16'hA5C3, 16'h0001, 16'hFFFF,
                                          16'h8000, 16'h1234, 16'h0F0F};
  localparam logic        V_DROP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        V_STOP [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [NCH-1:0] smp_data = '0;
  logic [1:0] mode = 2'd0;
  logic cond_mode = 1'b0;
  logic cmd_keep = 1'b0, cmd_drop = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
  logic wr_en, mem_full;
  logic [AW-1:0] wr_addr;
  logic [NCH-1:0] wr_data;
  logic [TS_W-1:0] wr_ts;

  int checks = 0;
  int errors = 0;
  logic [63:0] tick = '0;
  logic [63:0] exp_ts = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench's own count of clock edges since reset release
  always @(posedge clk) tick <= rst ? 64'd0 : tick + 64'd1;

  cq_capture #(.NCH(NCH), .TS_W(TS_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .mode(mode), .cond_mode(cond_mode), .cmd_keep(cmd_keep),
    .cmd_drop(cmd_drop), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ts(wr_ts),
    .mem_full(mem_full)
  );

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    smp_vld = 1'b0; cmd_keep = 1'b0; cmd_drop = 1'b0;
    cmd_start = 1'b0; cmd_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic strobe(input logic [15:0] d, input logic k, input logic dr,
                        input logic sa, input logic sp);
    smp_data = d; cmd_keep = k; cmd_drop = dr; cmd_start = sa; cmd_stop = sp;
    smp_vld = 1'b1;
    exp_ts = tick;
    @(negedge clk);
    smp_vld = 1'b0; cmd_keep = 1'b0; cmd_drop = 1'b0;
    cmd_start = 1'b0; cmd_stop = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 wr_en", wr_en, 0);
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 mem_full", mem_full, 0);
    strobe(16'h4242, 0, 0, 0, 0);
    chk("R1 first ts", wr_ts, 0);
    chk("R1 first addr", wr_addr, 0);

    // R2/R6/R9/R5 table walk, continuous, commands must be ignored
    do_reset();
    for (int i = 0; i < NV; i++) begin
      strobe(V_DATA[i], 1'b0, V_DROP[i], 1'b0, V_STOP[i]);
      chk("R6 wr_en", wr_en, 1);
      chk("R2 wr_data", wr_data, V_DATA[i]);
      chk("R9 wr_addr", wr_addr, i);
      chk("R5 wr_ts", wr_ts, exp_ts);
      @(negedge clk);
      chk("R9 pulse one cycle", wr_en, 0);
    end
    mode = 2'd3;
    @(negedge clk);
    strobe(16'hBEEF, 0, 0, 0, 0);
    chk("R2 spare mode data", wr_data, 16'hBEEF);

    // R3 double rate
    do_reset();
    mode = 2'd1;
    @(negedge clk);
    strobe(16'hFF12, 0, 0, 0, 0);
    chk("R3 no write on first half", wr_en, 0);
    @(negedge clk);
    strobe(16'h0034, 0, 0, 0, 0);
    chk("R3 wr_en", wr_en, 1);
    chk("R3 wr_data", wr_data, 16'h3412);
    chk("R5 ts of final sub-sample", wr_ts, exp_ts);

    // R4 quad rate
    mode = 2'd2;
    @(negedge clk);
    strobe(16'hFFF1, 0, 0, 0, 0);
    strobe(16'h0002, 0, 0, 0, 0);
    strobe(16'hABC3, 0, 0, 0, 0);
    chk("R4 no early write", wr_en, 0);
    strobe(16'h0004, 0, 0, 0, 0);
    chk("R4 wr_en", wr_en, 1);
    chk("R4 wr_data", wr_data, 16'h4321);
    chk("R4 wr_addr", wr_addr, 1);
    chk("R5 ts quad", wr_ts, exp_ts);

    // R11 mode change drops partial word
    mode = 2'd1;
    @(negedge clk);
    strobe(16'h00AA, 0, 0, 0, 0);
    mode = 2'd2;
    @(negedge clk);
    mode = 2'd1;
    @(negedge clk);
    a = 16'h00BB; b = 16'h00CC;
    strobe(a, 0, 0, 0, 0);
    chk("R11 restart after change", wr_en, 0);
    strobe(b, 0, 0, 0, 0);
    chk("R11 new word", wr_data, {b[7:0], a[7:0]});

    // R7/R8 qualified storage
    do_reset();
    mode = 2'd0; cond_mode = 1'b1;
    @(negedge clk);
    strobe(16'h0001, 0, 0, 0, 0); chk("R7 off after reset", wr_en, 0);
    strobe(16'h0002, 1, 0, 0, 0); chk("R8 keep", wr_en, 1);
    chk("R8 keep addr", wr_addr, 0);
    strobe(16'h0003, 0, 0, 1, 0); chk("R7 start same cycle", wr_en, 1);
    strobe(16'h0004, 0, 0, 0, 0); chk("R7 sticky on", wr_en, 1);
    strobe(16'h0005, 0, 1, 0, 0); chk("R8 drop", wr_en, 0);
    strobe(16'h0006, 0, 0, 0, 0); chk("R8 drop one word only", wr_en, 1);
    chk("R9 addr after drops", wr_addr, 3);
    strobe(16'h0007, 0, 0, 0, 1); chk("R7 stop same cycle", wr_en, 0);
    strobe(16'h0008, 1, 0, 0, 0); chk("R8 keep while off", wr_en, 1);
    strobe(16'h0009, 0, 0, 0, 0); chk("R8 keep leaves sticky off", wr_en, 0);
    strobe(16'h000A, 0, 0, 1, 1); chk("R7 stop wins", wr_en, 0);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    strobe(16'h000B, 0, 0, 0, 0); chk("R7 start without strobe", wr_en, 1);
    chk("R7 data", wr_data, 16'h000B);
    strobe(16'h000C, 1, 1, 0, 0); chk("R8 drop wins", wr_en, 0);

    // R10 full
    do_reset();
    cond_mode = 1'b0;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) strobe(16'(i), 0, 0, 0, 0);
    chk("R10 full flag", mem_full, 1);
    chk("R10 last addr", wr_addr, DEPTH - 1);
    strobe(16'h7777, 0, 0, 0, 0);
    chk("R10 no write when full", wr_en, 0);
    chk("R10 data held", wr_data, DEPTH - 1);
    chk("R10 still full", mem_full, 1);
    do_reset();
    chk("R1 full cleared", mem_full, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule